// File: doc/BRIEF.md
# Serial Line Automatic Bit-Rate Handshake

This block sits behind the receive pin of an asynchronous serial port at power-up and works out which bit rate the host is using. The host sends 0x00 characters back to back; in 8N1 framing each one drives the line low for nine bit times, which are the start bit and eight zero data bits. A high stop bit of at least one bit time follows before the next character. The block times one such low stretch in clock cycles. It checks the length against the bit periods of the three rates it supports and, when one matches, fixes the divisor for that rate.

With the divisor fixed, the block sends a single 0x00 character back on its transmit line to show that its rate is set. It then waits for the host to answer with one 0x55 character. That byte, and only that byte, locks the block. After lock the divisor and the lock flag stay fixed until reset. A low time that fits no supported rate, a reply other than 0x55 or a silent host raises the error flag and sends the block back to timing the line. The host recovers by sending its 0x00 characters again.

Top module: `abr_autobaud`

## Requirements
- R1: After reset, txd_o is high (idle), locked_o and err_o are 0 and div_o is 0.
- R2: A low stretch is timed only if it begins with a falling edge that follows a high level seen while measuring. Its length L counts the clock cycles for which the line stays low. L is accepted when round(L/9) = (L+4)/9 lies within ±3% of a nominal divisor, that is |round(L/9) − N|·100 ≤ 3·N, where N = round(CLK_HZ/rate) for a rate of 4800, 9600 or 19200.
- R3: A low stretch that fits no nominal divisor sets err_o, sends nothing on txd_o and leaves the block measuring, so that a later valid low stretch is still accepted.
- R4: On acceptance, div_o takes the nominal divisor N of the matching rate.
- R5: After acceptance the block sends exactly one 8N1 frame of 0x00 in which every bit lasts div_o cycles. The line is low for 9·div_o cycles (start bit and eight zero data bits) and then goes high for the stop bit.
- R6: A received 0x55 (LSB first, sampled at mid-bit) with a high stop bit sets locked_o and clears err_o.
- R7: Any other byte, or a byte with a low stop bit, sets err_o and returns the block to measuring.
- R8: If no byte arrives within WD_BITS·N4800 cycles of the end of the reply frame, where N4800 = round(CLK_HZ/4800), err_o is set and the block returns to measuring.
- R9: Once locked, locked_o stays high, div_o does not change and txd_o stays high, whatever happens on rxd_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rxd_i | input | 1 | Serial receive line from the host |
| txd_o | output | 1 | Serial transmit line to the host, idles high |
| div_o | output | DIV_W | Derived clock cycles per bit, 0 until a rate is accepted |
| locked_o | output | 1 | Handshake complete |
| err_o | output | 1 | Last attempt failed, cleared by lock or reset |

## Verification
The assertions assume that rxd_i is a plain level whose edges fall on clock cycles. They also assume that the host speaks only when the handshake allows it, so the transmitter is idle whenever the block is measuring or locked. The bench drives the receive line on falling clock edges, holds each bit for a whole number of cycles equal to the nominal divisor, and sends the 0x55 confirmation only after the whole 0x00 reply has been seen. Low-time lengths are swept in steps across both tolerance edges of every rate on a reduced clock, and the expected accept or reject decision is computed from the rounding and tolerance arithmetic alone.

// File: rtl/abr_pkg.sv
package abr_pkg;
  typedef enum logic [1:0] {ST_MEAS, ST_ACK, ST_WAIT, ST_LOCK} abr_state_e;

  localparam int NUM_RATES = 3;

  // index 0 is the fastest rate, index 2 the slowest
  function automatic int rate_of(input int idx);
    case (idx)
      0:       return 19200;
      1:       return 9600;
      default: return 4800;
    endcase
  endfunction

  function automatic int nom_div(input int clk_hz, input int idx);
    return (clk_hz + rate_of(idx) / 2) / rate_of(idx);
  endfunction

  // smallest low time whose rounded ninth is within -3 %
  function automatic int cnt_lo(input int nom);
    return 9 * ((97 * nom + 99) / 100) - 4;
  endfunction

  // largest low time whose rounded ninth is within +3 %
  function automatic int cnt_hi(input int nom);
    return 9 * ((103 * nom) / 100) + 4;
  endfunction
endpackage

// File: rtl/abr_sync.sv
module abr_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {2{RST_VAL}};
    else        stg_q <= {stg_q[0], d};
  end

  assign q = stg_q[1];
endmodule

// File: rtl/abr_tx.sv
module abr_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    data,
  input  logic [DW-1:0] div,
  output logic          txd,
  output logic          busy
);
  logic [9:0]    sh_q, sh_d;
  logic [3:0]    bit_q, bit_d;
  logic [DW-1:0] tc_q, tc_d;
  logic          busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    tc_d   = tc_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (start) begin
        sh_d   = {1'b1, data, 1'b0};
        bit_d  = 4'd0;
        tc_d   = '0;
        busy_d = 1'b1;
      end
    end else if (tc_q == div - DW'(1)) begin
      tc_d = '0;
      sh_d = {1'b1, sh_q[9:1]};
      if (bit_q == 4'd9) busy_d = 1'b0;
      else               bit_d  = bit_q + 4'd1;
    end else begin
      tc_d = tc_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bit_q  <= '0;
      tc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      tc_q   <= tc_d;
      busy_q <= busy_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/abr_rx.sv
module abr_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rxd,
  input  logic [DW-1:0] div,
  output logic          vld,
  output logic [7:0]    data,
  output logic          stop_ok
);
  logic          act_q, act_d;
  logic          prev_q;
  logic [3:0]    bit_q, bit_d;
  logic [DW-1:0] tc_q, tc_d;
  logic [7:0]    sh_q, sh_d;
  logic          vld_q, vld_d;
  logic          ok_q, ok_d;
  logic [DW-1:0] lim;

  assign lim = (bit_q == 4'd0) ? ((div >> 1) - DW'(1)) : (div - DW'(1));

  always_comb begin
    act_d = act_q;
    bit_d = bit_q;
    tc_d  = tc_q;
    sh_d  = sh_q;
    ok_d  = ok_q;
    vld_d = 1'b0;
    if (!en) begin
      act_d = 1'b0;
    end else if (!act_q) begin
      if (prev_q && !rxd) begin
        act_d = 1'b1;
        bit_d = 4'd0;
        tc_d  = '0;
      end
    end else if (tc_q == lim) begin
      tc_d = '0;
      if (bit_q == 4'd0) begin
        if (rxd) act_d = 1'b0;
        else     bit_d = 4'd1;
      end else if (bit_q == 4'd9) begin
        vld_d = 1'b1;
        ok_d  = rxd;
        act_d = 1'b0;
      end else begin
        sh_d  = {rxd, sh_q[7:1]};
        bit_d = bit_q + 4'd1;
      end
    end else begin
      tc_d = tc_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      prev_q <= 1'b1;
      bit_q  <= '0;
      tc_q   <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      prev_q <= rxd;
      bit_q  <= bit_d;
      tc_q   <= tc_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
      ok_q   <= ok_d;
    end
  end

  assign vld     = vld_q;
  assign data    = sh_q;
  assign stop_ok = ok_q;
endmodule

// File: rtl/abr_autobaud.sv
module abr_autobaud #(
  parameter int CLK_HZ  = 33_000_000,
  parameter int WD_BITS = 30,
  parameter int DIV_W   = $clog2(abr_pkg::nom_div(CLK_HZ, 2) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  output logic             txd_o,
  output logic [DIV_W-1:0] div_o,
  output logic             locked_o,
  output logic             err_o
);
  import abr_pkg::*;

  localparam int CNT_MAX = cnt_hi(nom_div(CLK_HZ, 2)) + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int WD_CYC  = WD_BITS * nom_div(CLK_HZ, 2);
  localparam int WW      = $clog2(WD_CYC + 1);

  logic rst_s_n, rx_s;
  abr_sync #(.RST_VAL(1'b0)) u_rst_sync (.clk(clk), .rst_n(rst_n), .d(1'b1),  .q(rst_s_n));
  abr_sync #(.RST_VAL(1'b1)) u_rx_sync  (.clk(clk), .rst_n(rst_n), .d(rxd_i), .q(rx_s));

  abr_state_e       state_q, state_d;
  logic             rxp_q, armed_q, armed_d, run_q, run_d, err_q, err_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WW-1:0]    wd_q, wd_d;
  logic [DIV_W-1:0] div_q, div_d, sel_div;
  logic [NUM_RATES-1:0] hit;
  logic [DIV_W-1:0] cand [NUM_RATES];
  logic             tx_start, tx_busy, rx_vld, rx_ok;
  logic [7:0]       rx_byte;

  // one window comparator per supported rate
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int N = nom_div(CLK_HZ, g);
    assign hit[g]  = (cnt_q >= CW'(cnt_lo(N))) && (cnt_q <= CW'(cnt_hi(N)));
    assign cand[g] = DIV_W'(N);
  end

  always_comb begin
    sel_div = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--)
      if (hit[i]) sel_div = cand[i];
  end

  always_comb begin
    state_d  = state_q;
    armed_d  = armed_q;
    run_d    = run_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    div_d    = div_q;
    wd_d     = wd_q;
    tx_start = 1'b0;
    unique case (state_q)
      ST_MEAS: begin
        armed_d = armed_q | rx_s;
        if (run_q) begin
          if (!rx_s) begin
            if (cnt_q != CW'(CNT_MAX)) cnt_d = cnt_q + CW'(1);
          end else begin
            run_d = 1'b0;
            if (|hit) begin
              div_d    = sel_div;
              tx_start = 1'b1;
              state_d  = ST_ACK;
            end else begin
              err_d = 1'b1;
            end
          end
        end else if (armed_q && rxp_q && !rx_s) begin
          run_d = 1'b1;
          cnt_d = CW'(1);
        end
      end
      ST_ACK: begin
        if (!tx_busy) begin
          state_d = ST_WAIT;
          wd_d    = '0;
        end
      end
      ST_WAIT: begin
        wd_d = wd_q + WW'(1);
        if (rx_vld) begin
          if (rx_byte == 8'h55 && rx_ok) begin
            state_d = ST_LOCK;
            err_d   = 1'b0;
          end else begin
            err_d   = 1'b1;
            state_d = ST_MEAS;
          end
        end else if (wd_q == WW'(WD_CYC - 1)) begin
          err_d   = 1'b1;
          state_d = ST_MEAS;
        end
        if (state_d == ST_MEAS) begin
          armed_d = 1'b0;
          run_d   = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_MEAS;
      rxp_q   <= 1'b1;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      div_q   <= '0;
      wd_q    <= '0;
    end else begin
      state_q <= state_d;
      rxp_q   <= rx_s;
      armed_q <= armed_d;
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      div_q   <= div_d;
      wd_q    <= wd_d;
    end
  end

  abr_tx #(.DW(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .start(tx_start), .data(8'h00),
    .div(div_q), .txd(txd_o), .busy(tx_busy)
  );

  abr_rx #(.DW(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .en(state_q == ST_WAIT), .rxd(rx_s),
    .div(div_q), .vld(rx_vld), .data(rx_byte), .stop_ok(rx_ok)
  );

  assign div_o    = div_q;
  assign locked_o = (state_q == ST_LOCK);
  assign err_o    = err_q;
endmodule

// File: rtl/abr_autobaud_chk.sv
module abr_autobaud_chk #(
  parameter int CLK_HZ = 33_000_000,
  parameter int DIV_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               txd,
  input logic [DIV_W-1:0]   div,
  input logic               locked,
  input logic               err,
  input abr_pkg::abr_state_e st
);
  import abr_pkg::*;

  logic div_legal;
  assign div_legal = (div == DIV_W'(nom_div(CLK_HZ, 0))) ||
                     (div == DIV_W'(nom_div(CLK_HZ, 1))) ||
                     (div == DIV_W'(nom_div(CLK_HZ, 2)));

  AST_LOCK_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked);           // R9
  AST_DIV_FROZEN:  assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(div));     // R9
  AST_TX_IDLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) locked |-> txd);           // R9
  AST_TX_IDLE_MEAS: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_MEAS) |-> txd);    // R3
  AST_LOCK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) locked |-> !err);             // R6
  AST_DIV_LEGAL:   assert property (@(posedge clk) disable iff (!rst_n) (!txd) |-> div_legal);        // R4
endmodule

bind abr_autobaud abr_autobaud_chk #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd_o), .div(div_o),
  .locked(locked_o), .err(err_o), .st(state_q)
);

// File: tb/abr_autobaud_bench.sv
`timescale 1ns/1ps
module abr_autobaud_bench;
  localparam int CLK  = 960_000;
  localparam int WDB  = 30;
  localparam int BW   = 8;

  logic clk, rst_n, rxd;
  logic txd;
  logic [BW-1:0] div;
  logic locked, err;

  int n_run, n_fail;
  bit mon_en, tx_low_seen;

  abr_autobaud #(.CLK_HZ(CLK), .WD_BITS(WDB), .DIV_W(BW)) u_abr_autobaud (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_o(txd),
    .div_o(div), .locked_o(locked), .err_o(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (mon_en && !txd) tx_low_seen = 1'b1;

  function automatic int nom(input int r);
    return (CLK + r / 2) / r;
  endfunction

  // expected divisor for a low time, 0 when no rate fits
  function automatic int expect_div(input int l);
    int rates [3] = '{19200, 9600, 4800};
    int d = (l + 4) / 9;
    for (int i = 0; i < 3; i++) begin
      int n = nom(rates[i]);
      int dev = (d > n) ? d - n : n - d;
      if (dev * 100 <= 3 * n) return n;
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rxd   = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_low(input int l);
    @(negedge clk);
    rxd = 1'b0;
    repeat (l) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int d, input bit stop);
    logic [9:0] fr = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = fr[i];
      repeat (d) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  // waits for the reply frame; returns its low length and stop-bit high length
  task automatic get_reply(input int d, output int low_len, output int hi_len);
    int w = 0;
    low_len = 0;
    hi_len  = 0;
    while (txd && w < 60) begin @(negedge clk); w++; end
    while (!txd && low_len < 20 * d) begin low_len++; @(negedge clk); end
    while (txd && hi_len < d) begin hi_len++; @(negedge clk); end
  endtask

  task automatic trial(input int l);
    int e, lo, hi;
    do_reset();
    e = expect_div(l);
    send_low(l);
    if (e != 0) begin
      get_reply(e, lo, hi);
      chk(div == BW'(e), $sformatf("R4 div for L=%0d", l), div, e);
      chk(lo == 9 * e, $sformatf("R5 reply low length L=%0d", l), lo, 9 * e);
      chk(hi == e, "R5 reply stop bit", hi, e);
      chk(err == 1'b0, "R2 accepted no err", err, 0);
      send_byte(8'h55, e, 1'b1);
      repeat (4) @(negedge clk);
      chk(locked == 1'b1, $sformatf("R6 lock L=%0d", l), locked, 1);
    end else begin
      tx_low_seen = 1'b0;
      mon_en = 1'b1;
      repeat (40) @(negedge clk);
      mon_en = 1'b0;
      chk(err == 1'b1, $sformatf("R3 reject err L=%0d", l), err, 1);
      chk(!tx_low_seen, "R3 no reply on reject", tx_low_seen, 0);
      chk(locked == 1'b0, "R3 not locked", locked, 0);
    end
  endtask

  initial begin : watchdog
    repeat (190_000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int rates [3] = '{19200, 9600, 4800};
    int lo, hi, n;
    n_run = 0; n_fail = 0; mon_en = 1'b0; tx_low_seen = 1'b0;
    rxd = 1'b1; rst_n = 1'b0;

    // R1 reset state
    do_reset();
    chk(txd == 1'b1,  "R1 txd idle", txd, 1);
    chk(locked == 1'b0, "R1 locked", locked, 0);
    chk(err == 1'b0,  "R1 err", err, 0);
    chk(div == '0,    "R1 div", div, 0);

    // R2 R3 R4 R5 R6: sweep low times across both tolerance edges of each rate
    for (int r = 0; r < 3; r++) begin
      int nn = nom(rates[r]);
      int c1 = 9 * nn * 97 / 100;
      int c2 = 9 * nn * 103 / 100;
      for (int k = -8; k <= 8; k += 4) trial(c1 + k);
      for (int k = -8; k <= 8; k += 4) trial(c2 + k);
    end

    // R3 gross mismatch then recovery without reset
    do_reset();
    send_low(300);
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R3 gross reject", err, 1);
    n = nom(9600);
    repeat (n) @(negedge clk);
    send_low(9 * n);
    get_reply(n, lo, hi);
    chk(lo == 9 * n, "R3 recovery reply", lo, 9 * n);
    send_byte(8'h55, n, 1'b1);
    repeat (4) @(negedge clk);
    chk(locked == 1'b1, "R6 lock after reject", locked, 1);
    chk(err == 1'b0, "R6 err cleared by lock", err, 0);

    // R2 a low level present at reset release is not timed
    rxd = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
    chk(err == 1'b0, "R2 untimed initial low", err, 0);
    n = nom(4800);
    send_low(9 * n);
    get_reply(n, lo, hi);
    chk(div == BW'(n), "R2 measure after idle", div, n);

    // R7 wrong byte then recovery
    send_byte(8'hAA, n, 1'b1);
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R7 wrong byte err", err, 1);
    chk(locked == 1'b0, "R7 wrong byte not locked", locked, 0);
    repeat (n) @(negedge clk);
    send_low(9 * n);
    get_reply(n, lo, hi);
    chk(lo == 9 * n, "R7 remeasure reply", lo, 9 * n);

    // R7 framing error on 0x55
    send_byte(8'h55, n, 1'b0);
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R7 bad stop bit err", err, 1);
    chk(locked == 1'b0, "R7 bad stop not locked", locked, 0);

    // R8 watchdog
    do_reset();
    n = nom(19200);
    send_low(9 * n);
    get_reply(n, lo, hi);
    repeat (WDB * nom(4800) - 100) @(negedge clk);
    chk(err == 1'b0, "R8 before timeout", err, 0);
    repeat (200) @(negedge clk);
    chk(err == 1'b1, "R8 after timeout", err, 1);
    chk(locked == 1'b0, "R8 not locked", locked, 0);

    // R9 lock holds against later traffic
    repeat (n) @(negedge clk);
    send_low(9 * n);
    get_reply(n, lo, hi);
    send_byte(8'h55, n, 1'b1);
    repeat (4) @(negedge clk);
    chk(locked == 1'b1, "R9 locked", locked, 1);
    tx_low_seen = 1'b0;
    mon_en = 1'b1;
    send_low(9 * nom(4800));
    repeat (50) @(negedge clk);
    send_byte(8'h00, nom(9600), 1'b1);
    repeat (50) @(negedge clk);
    mon_en = 1'b0;
    chk(locked == 1'b1, "R9 still locked", locked, 1);
    chk(div == BW'(n), "R9 div unchanged", div, n);
    chk(!tx_low_seen, "R9 tx quiet", tx_low_seen, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule